// File: doc/BRIEF.md
# System Configuration Register Controller

This block holds the chip-level configuration that sits between the processor bus and several neighbouring cores. It selects which memory appears at address zero, steers five DMA requesters to alternate channels, picks which GPIO port drives each of sixteen external interrupt lines, chooses the source of a modulation envelope, and collects the enables that route fault sources onto a timer break input. Software reaches all of it through a single-cycle register port. Writes take effect on the next clock edge and reads are combinational.

Two resets act on the block. A system reset clears everything. On the first clock after it, the block loads the address-zero alias from the option-byte boot value. A peripheral bus reset clears the DMA steering, envelope selection and interrupt line selection, but it leaves the alias alone. It also leaves the break enables alone, because once set those can only be cleared by a system reset. The timer break output is the OR of each fault source gated by its enable, registered once.

Top module: `sysconf_ctrl`

## Requirements
- R1: The alias field in the configuration word (offset 0x00, bits [1:0]) drives `mem_alias` one-hot. Code 0 gives main flash (bit 0), code 1 gives system flash (bit 1), code 2 gives SRAM (bit 2), and code 3 gives main flash.
- R2: On the first clock after system reset the alias field takes `boot_mode`. A peripheral bus reset leaves it unchanged, and so do writes made while that reset is held.
- R3: A peripheral bus reset clears the DMA steering bits, the envelope code and all sixteen line select fields to zero.
- R4: Configuration bits [8:4] drive `dma_remap[4:0]` directly, with a set bit meaning the alternate channel: bit 0 timer A 1→2, bit 1 timer B 3→4, bit 2 UART receive 3→5, bit 3 UART transmit 2→4, bit 4 ADC 1→2.
- R5: Line select words sit at 0x08, 0x0C, 0x10 and 0x14. Line n uses word n>>2, bits [4*(n%4)+3:4*(n%4)]. Bits 31:16 read zero and all written bits read back.
- R6: Line code 0..5 routes pin n of port A..F to `line_out[n]`. Port p pin i is `gpio_pins[16*p+i]`. Codes 6..15 make the line inactive (0).
- R7: Port F (code 5) has only pins 0..10, so lines 11..15 with code 5 are inactive.
- R8: The break enable word (0x18) has bit 0 for the supply monitor, bit 1 for SRAM parity and bit 2 for CPU lockup. A write only sets bits. Neither a zero write nor a peripheral bus reset clears them; a system reset does.
- R9: `timer_break` is 1 in the cycle after one where some `brk_src[i]` and its stored enable are both 1. An enable written in the same cycle a source rises acts one cycle later.
- R10: Configuration bits [13:12] select the envelope: 0 timer (`env_sel` bit 0), 1 UART1 (bit 1), 2 UART2 (bit 2). Code 3 reads back as 3 and drives `env_sel` to 0.
- R11: Reads of any other address, including unaligned ones, return 0. Writes to them change no state.
- R12: After system reset every register reads zero except the alias field, `timer_break` is 0, and every line follows port A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst_n | input | 1 | System reset, active low |
| bus_rst_n | input | 1 | Peripheral bus reset, active low |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational, zero when not selected |
| boot_mode | input | 2 | Option-byte alias code |
| gpio_pins | input | 96 | Six ports of 16 pins, port p pin i at bit 16*p+i |
| brk_src | input | 3 | Fault sources: supply monitor, SRAM parity, lockup |
| line_out | output | 16 | Selected interrupt lines |
| dma_remap | output | 5 | DMA channel steering |
| mem_alias | output | 3 | One-hot address-zero target |
| env_sel | output | 3 | One-hot envelope source |
| timer_break | output | 1 | Registered combined break |

## Verification
Two events can meet in one cycle: a write that sets a break enable, and the rise of the fault source that enable gates. The bench drives both in the same cycle. It then expects `timer_break` to stay low for one cycle and rise in the next, and to fall one cycle after the source drops. A second overlap pairs a peripheral bus reset with earlier writes. It is judged by reading back the alias and break words unchanged and every reset-domain field at zero.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int CFG_OFF   = 'h00;
  localparam int LSEL_OFF  = 'h08;
  localparam int BRK_OFF   = 'h18;

  localparam int ALIAS_LSB = 0;
  localparam int DMA_LSB   = 4;
  localparam int ENV_LSB   = 12;

  typedef enum logic [1:0] {
    ALIAS_MAIN  = 2'd0,
    ALIAS_SYS   = 2'd1,
    ALIAS_SRAM  = 2'd2,
    ALIAS_SPARE = 2'd3
  } alias_code_e;

  typedef enum logic [1:0] {
    ENV_TIMER = 2'd0,
    ENV_UART1 = 2'd1,
    ENV_UART2 = 2'd2,
    ENV_NONE  = 2'd3
  } env_code_e;
endpackage

// File: rtl/sc_cfg_reg.sv
module sc_cfg_reg
  import sc_pkg::*;
#(
  parameter int DMA_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              sys_rst_n,
  input  logic              periph_rst_n,
  input  logic              bus_rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wd_alias,
  input  logic [DMA_W-1:0]  wd_dma,
  input  logic [1:0]        wd_env,
  input  logic [1:0]        boot_mode,
  output logic [DATA_W-1:0] rd_word,
  output logic [2:0]        mem_alias,
  output logic [DMA_W-1:0]  dma_remap,
  output logic [2:0]        env_sel
);
  logic [1:0]       alias_q, alias_d;
  logic             boot_pend_q;
  logic             alias_en;
  logic [DMA_W-1:0] dma_q, dma_d;
  logic [1:0]       env_q, env_d;

  // alias: system-reset domain, boot value captured on first clock
  always_comb begin
    alias_en = boot_pend_q | wr_en;
    alias_d  = alias_q;
    if (boot_pend_q) alias_d = boot_mode;
    else if (wr_en)  alias_d = wd_alias;
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      alias_q     <= '0;
      boot_pend_q <= 1'b1;
    end else begin
      boot_pend_q <= 1'b0;
      if (alias_en) alias_q <= alias_d;
    end
  end

  // steering fields: peripheral-reset domain
  always_comb begin
    dma_d = dma_q;
    env_d = env_q;
    if (wr_en) begin
      dma_d = wd_dma;
      env_d = wd_env;
    end
  end

  always_ff @(posedge clk or negedge periph_rst_n) begin
    if (!periph_rst_n) begin
      dma_q <= '0;
      env_q <= '0;
    end else if (wr_en) begin
      dma_q <= dma_d;
      env_q <= env_d;
    end
  end

  always_comb begin
    rd_word = '0;
    rd_word[ALIAS_LSB +: 2]   = alias_q;
    rd_word[DMA_LSB +: DMA_W] = dma_q;
    rd_word[ENV_LSB +: 2]     = env_q;
  end

  always_comb begin
    case (alias_code_e'(alias_q))
      ALIAS_SYS:  mem_alias = 3'b010;
      ALIAS_SRAM: mem_alias = 3'b100;
      default:    mem_alias = 3'b001;
    endcase
    case (env_code_e'(env_q))
      ENV_TIMER: env_sel = 3'b001;
      ENV_UART1: env_sel = 3'b010;
      ENV_UART2: env_sel = 3'b100;
      default:   env_sel = 3'b000;
    endcase
  end

  assign dma_remap = dma_q;

  // R2: alias untouched across a bus reset
  a_r2_alias_hold: assert property (@(posedge clk) disable iff (!sys_rst_n)
    ($past(!bus_rst_n) && !$past(boot_pend_q)) |-> $stable(alias_q));

  // R3: bus reset leaves steering fields cleared
  a_r3_bus_clear: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !bus_rst_n |-> (dma_remap == '0 && env_sel == 3'b001));

  // R10: spare envelope code drives nothing
  a_r10_env_spare: assert property (@(posedge clk) disable iff (!periph_rst_n)
    (rd_word[ENV_LSB +: 2] == 2'd3) |-> (env_sel == 3'b000));
endmodule

// File: rtl/sc_line_mux.sv
module sc_line_mux #(
  parameter int LINES     = 16,
  parameter int PORTS     = 6,
  parameter int PINS      = 16,
  parameter int LAST_PINS = 11,
  parameter int FIELD_W   = 4,
  parameter int PER_REG   = 4,
  parameter int DATA_W    = 32,
  localparam int REGS     = LINES / PER_REG,
  localparam int IDX_W    = (REGS > 1) ? $clog2(REGS) : 1,
  localparam int PIN_IW   = $clog2(PORTS * PINS),
  localparam int USED_W   = PER_REG * FIELD_W
) (
  input  logic                  clk,
  input  logic                  periph_rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      idx,
  input  logic [USED_W-1:0]     wd,
  input  logic [PORTS*PINS-1:0] pins,
  output logic [DATA_W-1:0]     rd_word,
  output logic [LINES-1:0]      line_out
);
  logic [FIELD_W-1:0] sel_q [LINES];
  logic [FIELD_W-1:0] sel_d [LINES];
  logic [REGS-1:0]    reg_en;

  always_comb begin
    for (int r = 0; r < REGS; r++) reg_en[r] = wr_en && (int'(idx) == r);
    for (int n = 0; n < LINES; n++) begin
      sel_d[n] = sel_q[n];
      if (reg_en[n / PER_REG]) sel_d[n] = wd[(n % PER_REG)*FIELD_W +: FIELD_W];
    end
  end

  for (genvar n = 0; n < LINES; n++) begin : g_sel
    always_ff @(posedge clk or negedge periph_rst_n) begin
      if (!periph_rst_n)            sel_q[n] <= '0;
      else if (reg_en[n / PER_REG]) sel_q[n] <= sel_d[n];
    end
  end

  always_comb begin
    rd_word = '0;
    for (int j = 0; j < PER_REG; j++)
      rd_word[j*FIELD_W +: FIELD_W] = sel_q[int'(idx)*PER_REG + j];
  end

  for (genvar n = 0; n < LINES; n++) begin : g_line
    logic              bit_v;
    logic [PIN_IW-1:0] pin_idx;
    assign pin_idx = PIN_IW'(sel_q[n]) * PIN_IW'(PINS) + PIN_IW'(n);
    always_comb begin
      bit_v = 1'b0;
      if (int'(sel_q[n]) < PORTS) begin
        if (!(int'(sel_q[n]) == PORTS-1 && n >= LAST_PINS)) bit_v = pins[pin_idx];
      end
    end
    assign line_out[n] = bit_v;

    if (n >= LAST_PINS) begin : g_short
      // R7: last port has no pin here
      a_r7_last_port_idle: assert property (@(posedge clk) disable iff (!periph_rst_n)
        (sel_q[n] == FIELD_W'(PORTS-1)) |-> !line_out[n]);
    end
  end
endmodule

// File: rtl/sc_break_ctl.sv
module sc_break_ctl #(
  parameter int SRC_W = 3
) (
  input  logic             clk,
  input  logic             sys_rst_n,
  input  logic             wr_en,
  input  logic [SRC_W-1:0] wd,
  input  logic [SRC_W-1:0] brk_src,
  output logic [SRC_W-1:0] en_q,
  output logic             timer_break
);
  logic [SRC_W-1:0] en_d;
  logic             brk_d, brk_q;

  always_comb begin
    en_d  = en_q;
    if (wr_en) en_d = en_q | wd;
    brk_d = |(brk_src & en_q);
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      en_q  <= '0;
      brk_q <= 1'b0;
    end else begin
      if (wr_en) en_q <= en_d;
      brk_q <= brk_d;
    end
  end

  assign timer_break = brk_q;

  // R8: an enable once set stays set until system reset
  a_r8_sticky: assert property (@(posedge clk) disable iff (!sys_rst_n)
    1'b1 |=> ((en_q & $past(en_q)) == $past(en_q)));

  // R9: no stored enable, no break next cycle
  a_r9_no_enable: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (en_q == '0) |=> !timer_break);
endmodule

// File: rtl/sysconf_ctrl.sv
module sysconf_ctrl
  import sc_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int LINES     = 16,
  parameter int PORTS     = 6,
  parameter int PINS      = 16,
  parameter int LAST_PINS = 11,
  parameter int DMA_W     = 5,
  parameter int SRC_W     = 3
) (
  input  logic                  clk,
  input  logic                  sys_rst_n,
  input  logic                  bus_rst_n,
  input  logic                  reg_sel,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic [1:0]            boot_mode,
  input  logic [PORTS*PINS-1:0] gpio_pins,
  input  logic [SRC_W-1:0]      brk_src,
  output logic [LINES-1:0]      line_out,
  output logic [DMA_W-1:0]      dma_remap,
  output logic [2:0]            mem_alias,
  output logic [2:0]            env_sel,
  output logic                  timer_break
);
  localparam int FIELD_W = 4;
  localparam int PER_REG = 4;
  localparam int REGS    = LINES / PER_REG;
  localparam int IDX_W   = (REGS > 1) ? $clog2(REGS) : 1;
  localparam int USED_W  = PER_REG * FIELD_W;

  logic              periph_rst_n;
  logic              wr_ok;
  logic              hit_cfg, hit_lsel, hit_brk, hit_any;
  logic [ADDR_W-1:0] lsel_off;
  logic [IDX_W-1:0]  lsel_idx;
  logic [DATA_W-1:0] cfg_rd, lsel_rd;
  logic [SRC_W-1:0]  brk_en;
  logic              unused_ok;

  assign periph_rst_n = sys_rst_n & bus_rst_n;
  assign wr_ok        = reg_sel & reg_wr & bus_rst_n;

  always_comb begin
    lsel_off = reg_addr - ADDR_W'(LSEL_OFF);
    lsel_idx = lsel_off[2 +: IDX_W];
    hit_cfg  = (reg_addr == ADDR_W'(CFG_OFF));
    hit_brk  = (reg_addr == ADDR_W'(BRK_OFF));
    hit_lsel = (reg_addr >= ADDR_W'(LSEL_OFF)) &&
               (int'(lsel_off) < REGS*4) && (lsel_off[1:0] == 2'b00);
    hit_any  = hit_cfg | hit_lsel | hit_brk;
  end

  sc_cfg_reg #(.DMA_W(DMA_W), .DATA_W(DATA_W)) u_cfg (
    .clk          (clk),
    .sys_rst_n    (sys_rst_n),
    .periph_rst_n (periph_rst_n),
    .bus_rst_n    (bus_rst_n),
    .wr_en        (wr_ok & hit_cfg),
    .wd_alias     (reg_wdata[ALIAS_LSB +: 2]),
    .wd_dma       (reg_wdata[DMA_LSB +: DMA_W]),
    .wd_env       (reg_wdata[ENV_LSB +: 2]),
    .boot_mode    (boot_mode),
    .rd_word      (cfg_rd),
    .mem_alias    (mem_alias),
    .dma_remap    (dma_remap),
    .env_sel      (env_sel)
  );

  sc_line_mux #(
    .LINES(LINES), .PORTS(PORTS), .PINS(PINS), .LAST_PINS(LAST_PINS),
    .FIELD_W(FIELD_W), .PER_REG(PER_REG), .DATA_W(DATA_W)
  ) u_lines (
    .clk          (clk),
    .periph_rst_n (periph_rst_n),
    .wr_en        (wr_ok & hit_lsel),
    .idx          (lsel_idx),
    .wd           (reg_wdata[USED_W-1:0]),
    .pins         (gpio_pins),
    .rd_word      (lsel_rd),
    .line_out     (line_out)
  );

  sc_break_ctl #(.SRC_W(SRC_W)) u_brk (
    .clk         (clk),
    .sys_rst_n   (sys_rst_n),
    .wr_en       (wr_ok & hit_brk),
    .wd          (reg_wdata[SRC_W-1:0]),
    .brk_src     (brk_src),
    .en_q        (brk_en),
    .timer_break (timer_break)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_sel) begin
      if (hit_cfg)       reg_rdata = cfg_rd;
      else if (hit_lsel) reg_rdata = lsel_rd;
      else if (hit_brk)  reg_rdata[SRC_W-1:0] = brk_en;
    end
  end

  assign unused_ok = ^{reg_wdata, lsel_off};

  // R11: unmapped address reads zero
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (reg_sel && !hit_any) |-> (reg_rdata == '0));
endmodule

// File: tb/sysconf_ctrl_bench.sv
module sysconf_ctrl_bench;
  logic        clk = 1'b0;
  logic        sys_rst_n, bus_rst_n;
  logic        reg_sel, reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [1:0]  boot_mode;
  logic [95:0] gpio_pins;
  logic [2:0]  brk_src;
  logic [15:0] line_out;
  logic [4:0]  dma_remap;
  logic [2:0]  mem_alias, env_sel;
  logic        timer_break;

  int n_chk = 0;
  int n_err = 0;
  logic [15:0] shadow [4];

  always #4 clk = ~clk;

  sysconf_ctrl u_sysconf_ctrl (
    .clk(clk), .sys_rst_n(sys_rst_n), .bus_rst_n(bus_rst_n),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .boot_mode(boot_mode),
    .gpio_pins(gpio_pins), .brk_src(brk_src), .line_out(line_out),
    .dma_remap(dma_remap), .mem_alias(mem_alias), .env_sel(env_sel),
    .timer_break(timer_break)
  );

  function automatic logic exp_line(int n, logic [3:0] code, logic [95:0] p);
    if (code > 4'd5) return 1'b0;
    if (code == 4'd5 && n > 10) return 1'b0;
    return p[int'(code)*16 + n];
  endfunction

  function automatic logic [15:0] exp_lines(logic [95:0] p);
    logic [15:0] v;
    for (int n = 0; n < 16; n++) v[n] = exp_line(n, shadow[n/4][(n%4)*4 +: 4], p);
    return v;
  endfunction

  function automatic logic [2:0] exp_alias(logic [1:0] c);
    return (c == 2'd1) ? 3'b010 : (c == 2'd2) ? 3'b100 : 3'b001;
  endfunction

  function automatic logic [2:0] exp_env(logic [1:0] c);
    return (c == 2'd3) ? 3'b000 : 3'(1 << c);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    reg_sel = 1'b0;
  endtask

  task automatic sys_reset(logic [1:0] bm);
    @(negedge clk);
    sys_rst_n = 1'b0; boot_mode = bm;
    repeat (3) @(negedge clk);
    sys_rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 4; k++) shadow[k] = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int unsigned seed_init;
    seed_init = $urandom(32'd2024);
    sys_rst_n = 1'b1; bus_rst_n = 1'b1; reg_sel = 1'b0; reg_wr = 1'b0;
    reg_addr = '0; reg_wdata = '0; boot_mode = '0; brk_src = '0;
    gpio_pins = {$urandom, $urandom, $urandom};

    // R12 / R2: reset state with boot code 1
    sys_reset(2'd1);
    rd(8'h00, d); chk("R12 cfg reset", d, 32'h1);
    for (int k = 0; k < 4; k++) begin
      rd(8'(8 + 4*k), d); chk("R12 lsel reset", d, 0);
    end
    rd(8'h18, d); chk("R12 brk reset", d, 0);
    chk("R2 boot alias", 32'(mem_alias), 32'(3'b010));
    chk("R12 lines port A", 32'(line_out), 32'(gpio_pins[15:0]));
    chk("R12 break low", 32'(timer_break), 0);

    // R1 alias codes
    for (int c = 0; c < 4; c++) begin
      wr(8'h00, 32'(c));
      @(negedge clk);
      chk("R1 alias out", 32'(mem_alias), 32'(exp_alias(2'(c))));
      rd(8'h00, d); chk("R1 alias readback", d, 32'(c));
    end

    // R4 / R10 steering and envelope
    for (int c = 0; c < 4; c++) begin
      logic [4:0] dm;
      dm = 5'($urandom);
      wr(8'h00, (32'(c) << 12) | (32'(dm) << 4));
      @(negedge clk);
      chk("R4 dma steer", 32'(dma_remap), 32'(dm));
      chk("R10 env out", 32'(env_sel), 32'(exp_env(2'(c))));
      rd(8'h00, d); chk("R10 env readback", d, (32'(c) << 12) | (32'(dm) << 4));
    end
    wr(8'h00, 32'h1F << 4);
    @(negedge clk); chk("R4 all remapped", 32'(dma_remap), 32'h1F);

    // R5 / R6 / R7 random line selection
    for (int it = 0; it < 60; it++) begin
      int k;
      logic [31:0] w;
      k = int'($urandom % 4);
      w = $urandom;
      wr(8'(8 + 4*k), w);
      shadow[k] = w[15:0];
      gpio_pins = {$urandom, $urandom, $urandom};
      @(negedge clk);
      chk("R6 lines random", 32'(line_out), 32'(exp_lines(gpio_pins)));
      rd(8'(8 + 4*k), d); chk("R5 lsel readback", d, 32'(w[15:0]));
    end

    // R7 directed: port F on every line, all pins high
    for (int k = 0; k < 4; k++) begin
      wr(8'(8 + 4*k), 32'h5555);
      shadow[k] = 16'h5555;
    end
    gpio_pins = '1;
    @(negedge clk);
    chk("R7 port F lines", 32'(line_out), 32'h07FF);
    // R6 directed: unused codes
    for (int k = 0; k < 4; k++) begin
      wr(8'(8 + 4*k), 32'hF9A6);
      shadow[k] = 16'hF9A6;
    end
    @(negedge clk);
    chk("R6 unused codes", 32'(line_out), 0);
    // R5 directed: line 6 to port C, others port A
    for (int k = 0; k < 4; k++) begin
      wr(8'(8 + 4*k), (k == 1) ? 32'h0200 : 32'h0);
      shadow[k] = (k == 1) ? 16'h0200 : 16'h0;
    end
    gpio_pins = '0;
    gpio_pins[32 + 6] = 1'b1;
    @(negedge clk);
    chk("R5 line6 port C", 32'(line_out), 32'h0040);

    // R11 unmapped
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h0A, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h04, d); chk("R11 read 04", d, 0);
    rd(8'h0A, d); chk("R11 read 0A", d, 0);
    rd(8'h40, d); chk("R11 read 40", d, 0);
    rd(8'h08, d); chk("R11 lsel kept", d, 0);
    rd(8'h0C, d); chk("R11 lsel kept", d, 32'h0200);
    rd(8'h18, d); chk("R11 brk kept", d, 0);
    rd(8'h00, d); chk("R11 cfg kept", d, 32'h1F0);

    // R9 enable write and source rise in the same cycle
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = 8'h18; reg_wdata = 32'h1;
    brk_src = 3'b001;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
    chk("R9 same-cycle enable late", 32'(timer_break), 0);
    @(negedge clk);
    chk("R9 break rises", 32'(timer_break), 1);
    brk_src = 3'b000;
    @(negedge clk);
    chk("R9 break falls", 32'(timer_break), 0);
    brk_src = 3'b100;
    @(negedge clk); @(negedge clk);
    chk("R9 unenabled source", 32'(timer_break), 0);
    brk_src = 3'b000;

    // R8 set-only
    wr(8'h18, 32'h2);
    rd(8'h18, d); chk("R8 set only", d, 32'h3);
    wr(8'h18, 32'h0);
    rd(8'h18, d); chk("R8 zero write", d, 32'h3);

    // R3 / R2 / R8 bus reset
    wr(8'h00, 32'h2000 | (32'h15 << 4) | 32'h2);
    wr(8'h10, 32'h1234); shadow[2] = 16'h1234;
    @(negedge clk);
    bus_rst_n = 1'b0;
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = 8'h00; reg_wdata = 32'h1;
    @(negedge clk); @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
    bus_rst_n = 1'b1;
    for (int k = 0; k < 4; k++) shadow[k] = '0;
    @(negedge clk);
    rd(8'h00, d); chk("R2 R3 cfg after bus reset", d, 32'h2);
    chk("R2 alias kept", 32'(mem_alias), 32'(3'b100));
    chk("R3 dma cleared", 32'(dma_remap), 0);
    chk("R3 env timer", 32'(env_sel), 32'(3'b001));
    rd(8'h10, d); chk("R3 lsel cleared", d, 0);
    rd(8'h18, d); chk("R8 brk survives", d, 32'h3);
    brk_src = 3'b010;
    @(negedge clk); @(negedge clk);
    chk("R9 parity break", 32'(timer_break), 1);
    brk_src = 3'b000;

    // R8 / R2 system reset clears enables, loads boot code 2
    sys_reset(2'd2);
    rd(8'h18, d); chk("R8 sys reset clears", d, 0);
    chk("R2 boot SRAM", 32'(mem_alias), 32'(3'b100));
    rd(8'h00, d); chk("R12 cfg boot", d, 32'h2);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule